// File: doc/BRIEF.md
# MII Nibble to 5B Code Group Encoder

This block is the transmit front end of a 100 Mbps twisted-pair physical layer. Each clock it takes one nibble from the media independent interface and returns one registered 5-bit code group, which goes on to a scrambler. The block builds the frame boundaries itself. It puts a start delimiter in place of the first two preamble nibbles. It appends an end delimiter once transmit enable drops. Between frames it fills the line with IDLE. A nibble flagged with a transmit error is replaced by the HALT code group.

A static bypass input skips the framing and the 4B/5B table. In bypass the error input becomes the fifth bit of a raw symbol that the MAC side has already coded. The block then only registers the symbol.

Top module: `mii_4b5b_encoder`

## Requirements
- R1: During reset, and in every cycle with no frame in progress, `sym` is the IDLE code group 11111.
- R2: Each output is registered one clock after the nibble that produced it. When `tx_en` rises, the first two nibbles of the frame are replaced by J (11000) and then K (10001).
- R3: Nibbles after the first two are mapped to the 4B/5B data code groups. The mapping is 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R4: A data-phase nibble with `tx_en` and `tx_er` both high is sent as HALT (00100). `tx_er` has no effect on the two nibbles that become J and K.
- R5: In the first cycle with `tx_en` low after a data phase, the block emits T (01101). R (00111) follows, and then IDLE.
- R6: If `tx_en` is high for a single nibble, the output is J, K, T, R, then IDLE. The J/K pair always completes before the end delimiter.
- R7: With `bypass` high, a cycle with `tx_en` high outputs {`tx_er`, `txd[3:0]`} (bit 4 = `tx_er`) one clock later, with no delimiters added. A cycle with `tx_en` low outputs IDLE.
- R8: After R has been emitted, a new frame may start with only two low cycles of `tx_en`. Its J then directly follows the previous R.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass | input | 1 | Static mode select: raw 5-bit symbols, no encoding |
| tx_en | input | 1 | Nibble valid / frame in progress |
| tx_er | input | 1 | Transmit error; fifth symbol bit in bypass |
| txd | input | 4 | Transmit nibble |
| sym | output | 5 | Registered 5-bit code group |

## Verification
The bench sends frames of many lengths, so every nibble value passes through the data table. A wrong table entry or an off-by-one latency shows up as a mismatched code group. Single-nibble frames check that the block emits K before T, and do not let it skip K or cut J/K short. The error flag is driven on the preamble positions and on a data position. A design that applied HALT too early would corrupt the start delimiter, and one that ignored the flag would send data. Frames separated by exactly two low cycles check that J follows R at once. A full sweep of all 32 raw symbols in bypass catches a dropped fifth bit or a delimiter inserted where none belongs.

// File: rtl/mii_4b5b_encoder.sv
module mii_4b5b_encoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bypass,
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic [3:0] txd,
  output logic [4:0] sym
);

  localparam logic [4:0] SYM_I = 5'b11111;
  localparam logic [4:0] SYM_J = 5'b11000;
  localparam logic [4:0] SYM_K = 5'b10001;
  localparam logic [4:0] SYM_T = 5'b01101;
  localparam logic [4:0] SYM_R = 5'b00111;
  localparam logic [4:0] SYM_H = 5'b00100;

  typedef enum logic [2:0] {ST_IDLE, ST_K, ST_DATA, ST_T, ST_R} st_t;

  st_t        state, state_nx;
  logic [4:0] sym_nx;
  logic [4:0] data_sym;

  function automatic logic [4:0] enc4b5b(input logic [3:0] n);
    case (n)
      4'h0: enc4b5b = 5'b11110;
      4'h1: enc4b5b = 5'b01001;
      4'h2: enc4b5b = 5'b10100;
      4'h3: enc4b5b = 5'b10101;
      4'h4: enc4b5b = 5'b01010;
      4'h5: enc4b5b = 5'b01011;
      4'h6: enc4b5b = 5'b01110;
      4'h7: enc4b5b = 5'b01111;
      4'h8: enc4b5b = 5'b10010;
      4'h9: enc4b5b = 5'b10011;
      4'hA: enc4b5b = 5'b10110;
      4'hB: enc4b5b = 5'b10111;
      4'hC: enc4b5b = 5'b11010;
      4'hD: enc4b5b = 5'b11011;
      4'hE: enc4b5b = 5'b11100;
      default: enc4b5b = 5'b11101;
    endcase
  endfunction

  assign data_sym = tx_er ? SYM_H : enc4b5b(txd);

  always_comb begin
    state_nx = state;
    sym_nx   = SYM_I;
    if (bypass) begin
      state_nx = ST_IDLE;
      sym_nx   = tx_en ? {tx_er, txd} : SYM_I;
    end else begin
      case (state)
        ST_IDLE: if (tx_en) begin
          sym_nx   = SYM_J;
          state_nx = ST_K;
        end
        ST_K: begin
          sym_nx   = SYM_K;
          state_nx = tx_en ? ST_DATA : ST_T;
        end
        ST_DATA: if (tx_en) begin
          sym_nx = data_sym;
        end else begin
          sym_nx   = SYM_T;
          state_nx = ST_R;
        end
        ST_T: begin
          sym_nx   = SYM_T;
          state_nx = ST_R;
        end
        ST_R: begin
          sym_nx   = SYM_R;
          state_nx = ST_IDLE;
        end
        default: state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sym   <= SYM_I;
    end else begin
      state <= state_nx;
      sym   <= sym_nx;
    end
  end

  AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && state == ST_IDLE && !tx_en) |=> (sym == SYM_I)); // R1

  AST_J_BEFORE_K: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && $past(!bypass) && sym == SYM_J) |=> (bypass || sym == SYM_K)); // R2

  AST_HALT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && state == ST_DATA && tx_en && tx_er) |=> (sym == SYM_H)); // R4

  AST_T_BEFORE_R: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && $past(!bypass) && sym == SYM_T) |=> (bypass || sym == SYM_R)); // R5

  AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && tx_en) |=> (sym == $past({tx_er, txd}))); // R7

endmodule

// File: tb/test_mii_4b5b_encoder.sv
module test_mii_4b5b_encoder;

  localparam logic [4:0] E_I = 5'b11111;
  localparam logic [4:0] E_J = 5'b11000;
  localparam logic [4:0] E_K = 5'b10001;
  localparam logic [4:0] E_T = 5'b01101;
  localparam logic [4:0] E_R = 5'b00111;
  localparam logic [4:0] E_H = 5'b00100;
  localparam logic [79:0] CODES = {
    5'b11101, 5'b11100, 5'b11011, 5'b11010, 5'b10111, 5'b10110, 5'b10011, 5'b10010,
    5'b01111, 5'b01110, 5'b01011, 5'b01010, 5'b10101, 5'b10100, 5'b01001, 5'b11110};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bypass = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic [4:0] sym;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mii_4b5b_encoder i_mii_4b5b_encoder (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .tx_en(tx_en),
    .tx_er(tx_er), .txd(txd), .sym(sym));

  function automatic logic [4:0] code_of(input logic [3:0] n);
    return CODES[n*5 +: 5];
  endfunction

  task automatic check(input string req, input logic [4:0] exp);
    checks++;
    if (sym !== exp) begin
      errors++;
      $display("FAIL %s: sym=%b expected=%b at %0t", req, sym, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic er, input logic [3:0] d,
                      input logic [4:0] exp, input string req);
    tx_en = en; tx_er = er; txd = d;
    @(negedge clk);
    check(req, exp);
  endtask

  // frame of len nibbles; er_pos marks the nibble driven with tx_er (-1 none)
  task automatic frame(input int len, input int base, input int er_pos);
    for (int i = 0; i < len; i++) begin
      logic [3:0] d;
      logic [4:0] e;
      d = 4'((base + i * 7) % 16);
      if (i == 0) e = E_J;
      else if (i == 1) e = E_K;
      else if (i == er_pos) e = E_H;
      else e = code_of(d);
      step(1'b1, i == er_pos, d, e, i < 2 ? "R2/R4" : (i == er_pos ? "R4" : "R3"));
    end
    if (len == 1) step(1'b0, 1'b0, 4'h0, E_K, "R6");
    step(1'b0, 1'b0, 4'h0, E_T, "R5");
    step(1'b0, 1'b0, 4'h0, E_R, "R5");
  endtask

  initial begin
    tx_en = 1'b1; txd = 4'h5;
    repeat (3) @(negedge clk);
    check("R1", E_I);
    tx_en = 1'b0;
    rst_n = 1'b1;
    step(1'b0, 1'b1, 4'h3, E_I, "R1");
    step(1'b0, 1'b0, 4'h0, E_I, "R1");

    for (int b = 0; b < 16; b++) begin
      frame(2 + b, b, -1);
      step(1'b0, 1'b0, 4'h0, E_I, "R1");
    end

    frame(1, 9, 0);
    step(1'b0, 1'b0, 4'h0, E_I, "R6");
    frame(1, 3, -1);
    step(1'b0, 1'b0, 4'h0, E_I, "R6");
    frame(2, 4, 1);
    step(1'b0, 1'b0, 4'h0, E_I, "R5");

    for (int p = 0; p < 6; p++) begin
      frame(6, p, p);
      step(1'b0, 1'b0, 4'h0, E_I, "R4");
    end

    frame(5, 1, -1);
    frame(4, 2, 3);
    frame(1, 0, -1);
    frame(3, 6, -1);
    step(1'b0, 1'b0, 4'h0, E_I, "R8");

    bypass = 1'b1;
    step(1'b0, 1'b0, 4'h0, E_I, "R7");
    for (int v = 0; v < 32; v++) begin
      step(1'b1, v[4], v[3:0], 5'(v), "R7");
    end
    for (int v = 0; v < 32; v += 5) begin
      step(1'b0, v[4], v[3:0], E_I, "R7");
    end
    step(1'b1, 1'b1, 4'h8, 5'b11000, "R7");
    step(1'b1, 1'b0, 4'h1, 5'b00001, "R7");
    step(1'b0, 1'b0, 4'h0, E_I, "R7");
    bypass = 1'b0;
    step(1'b0, 1'b0, 4'h0, E_I, "R1");
    frame(3, 11, -1);
    step(1'b0, 1'b0, 4'h0, E_I, "R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule